// File: doc/BRIEF.md
# Infrared Serial Pulse Encoder

This block turns the serial output of a UART into short infrared pulses of the kind used by low-speed serial infrared links. Every space (logic 0) bit on the serial line becomes one narrow high pulse on the emitter drive. A mark (logic 1) bit leaves the emitter dark. All timing is counted in ticks of a bit-rate reference that runs at sixteen times the baud rate, so one bit cell is sixteen ticks.

The tick comes from one of two sources. The first is an external 16x baud clock pin, which is synchronised and edge-detected. The second is the block's own crystal-rate clock divided by a ratio chosen with a three-bit rate code. Two pulse shapes are available. The default pulse lasts three ticks and is placed after a seven-tick dark lead-in. The second shape, available only with the divided crystal clock, is a short fixed pulse of six crystal cycles. It is triggered by the rising edge of the default pulse, so its width does not depend on the rate code.

The whole design runs on the crystal clock `clk`. The serial input and the external 16x clock are treated as asynchronous and pass through two-stage synchronisers.

Top module: `irs_sir_encoder`

## Requirements
- R1: In default pulse mode, a space bit drives `ir_txd` low for 7 ticks after the cell starts, then high for exactly 3 ticks. With the divided clock at ratio N, the high time is exactly 3·N crystal cycles.
- R2: When space bits follow one another, a new pulse starts every 16 ticks. The rising edges of pulses in one frame are spaced by exactly 16·N crystal cycles times the difference of their bit positions.
- R3: A mark bit produces no pulse. While `txd` stays high, `ir_txd` stays low.
- R4: With `pulse_mode`=1 and `ext_sel`=0, every pulse is exactly 6 crystal cycles wide, for every rate code.
- R5: With `ext_sel`=1, `pulse_mode` has no effect and pulses keep the 3-tick width.
- R6: With `ext_sel`=0, the tick period in crystal cycles follows `rate_code`: 0→2, 1→4, 2→12, 3→24, 4→6, 5→48, 6→96, 7→96.
- R7: With `ext_sel`=1, one tick is taken per rising edge of `ext_clk16`, so a pulse is 3 external periods wide.
- R8: While `pwr_dn` is 1, `ir_txd` is 0 from the next clock on. The encoder state is cleared, so no leftover pulse appears after release.
- R9: While `rst_n` is 0 at a clock edge, `ir_txd` is 0 after that edge and the state is cleared. After reset, `ir_txd` is low.
- R10: With the divided clock, the first rising edge of `ir_txd` appears between 7·N+4 and 8·N+4 crystal cycles after `txd` falls. This delay covers synchronisation and tick phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-rate clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| txd | input | 1 | Serial data from the UART; asynchronous, idles high |
| ext_clk16 | input | 1 | External 16x baud clock; asynchronous |
| ext_sel | input | 1 | 1 = tick from `ext_clk16`, 0 = tick from divided `clk` |
| rate_code | input | 3 | Divide-ratio select for the internal tick |
| pulse_mode | input | 1 | 1 = fixed 6-cycle pulse (internal tick only) |
| pwr_dn | input | 1 | Power-down; silences and clears the encoder |
| ir_txd | output | 1 | Registered emitter drive, high = light |

## Verification
Power-down and an active pulse can meet in one cycle. The bench provokes this by raising `pwr_dn` on the first sampled high cycle of a pulse. It then judges that `ir_txd` is low at the very next sample and that no pulse appears once the line is released. Reset is forced at the same point in a pulse in the same way. A second collision happens at the end of a bit cell, where the cell counter wraps and a new space must be taken up in the same tick. The frame pattern puts two spaces back to back. The bench checks that the second rising edge lands exactly 16 ticks after the first, and that the pulse count equals the number of space bits at every rate code.

// File: rtl/irs_pkg.sv
// Package: shared constants and the rate-code to divide-ratio map.
// Assumes a three-bit rate code; the unused code maps to the slowest ratio.
package irs_pkg;

    localparam int unsigned RATE_CODE_W = 3;
    localparam int unsigned MAX_RATIO   = 96;
    localparam int unsigned DIV_W       = $clog2(MAX_RATIO);

    // Crystal cycles per 16x tick for each rate code.
    function automatic int unsigned rate_ratio(input logic [RATE_CODE_W-1:0] code);
        case (code)
            3'd0:    return 2;
            3'd1:    return 4;
            3'd2:    return 12;
            3'd3:    return 24;
            3'd4:    return 6;
            3'd5:    return 48;
            3'd6:    return 96;
            default: return 96;
        endcase
    endfunction

endpackage

// File: rtl/irs_sync.sv
// Module: multi-stage synchroniser for one asynchronous level.
// Assumes STAGES >= 1; RST_VAL is the idle level loaded at reset.
module irs_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop: capture the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= d;
                end
            end else begin : g_next
                // Later flops: let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/irs_tick_gen.sv
// Module: builds the one-cycle 16x baud tick enable.
// Assumes every divide ratio is at least 2, so internal ticks never touch.
// The external 16x clock is synchronised and its rising edge becomes a tick.
module irs_tick_gen
    import irs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pd,
    input  logic                   ext_sel,
    input  logic [RATE_CODE_W-1:0] rate_code,
    input  logic                   ext_clk16,
    output logic                   tick
);

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;
    logic             int_tick;
    logic             ext_s;
    logic             ext_d;
    logic             ext_tick;

    assign div_last = DIV_W'(rate_ratio(rate_code) - 1);
    assign int_tick = (div_cnt >= div_last);

    // Free-running divider; parked while the external clock is in use.
    always_ff @(posedge clk) begin
        if (!rst_n || pd || ext_sel) div_cnt <= '0;
        else if (int_tick)           div_cnt <= '0;
        else                         div_cnt <= div_cnt + 1'b1;
    end

    irs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_clk16),
        .q     (ext_s)
    );

    // Delayed copy of the synchronised external clock, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || pd) ext_d <= 1'b0;
        else              ext_d <= ext_s;
    end

    assign ext_tick = ext_s && !ext_d;
    assign tick     = ext_sel ? ext_tick : int_tick;

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n || pd)
        (!ext_sel && tick) |=> (ext_sel || !tick)); // R6

    AST_EXT_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n || pd)
        (ext_sel && tick) |=> !ext_tick); // R7

endmodule

// File: rtl/irs_sir_mod.sv
// Module: 3/16 bit-cell modulator running on the 16x tick enable.
// Assumes LEAD + HIGH <= CELL. A cell opens on a tick that sees a space;
// at the last tick of a cell the line is looked at again, so back-to-back
// spaces chain cells without a gap. Outside cells the output is dark.
module irs_sir_mod #(
    parameter int unsigned CELL = 16,
    parameter int unsigned LEAD = 7,
    parameter int unsigned HIGH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    input  logic tick,
    input  logic txd_s,
    output logic mod
);

    localparam int unsigned CNT_W = $clog2(CELL);
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(CELL - 1);
    localparam logic [CNT_W-1:0] HI_BEG = CNT_W'(LEAD);
    localparam logic [CNT_W-1:0] HI_END = CNT_W'(LEAD + HIGH);

    logic             active;
    logic [CNT_W-1:0] cnt;

    // Cell sequencer: open on a space, advance on ticks, re-arm at cell end.
    always_ff @(posedge clk) begin
        if (!rst_n || pd) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (tick) begin
            if (!active) begin
                active <= !txd_s;
                cnt    <= '0;
            end else if (cnt == LAST) begin
                active <= !txd_s;
                cnt    <= '0;
            end else begin
                cnt    <= cnt + 1'b1;
            end
        end
    end

    assign mod = active && (cnt >= HI_BEG) && (cnt < HI_END);

    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n || pd)
        !tick |=> ($stable(cnt) && $stable(active))); // R1

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || pd)
        !active |-> (cnt == '0)); // R3

    AST_OPEN_ON_SPACE: assert property (@(posedge clk) disable iff (!rst_n || pd)
        $rose(active) |-> ($past(txd_s) == 1'b0)); // R2

endmodule

// File: rtl/irs_oneshot.sv
// Module: fixed-width pulse stretcher counted in crystal cycles.
// Assumes the trigger stays high for at least LEN cycles, so a pulse always
// ends before the next trigger edge can arrive.
module irs_oneshot #(
    parameter int unsigned LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    input  logic trig,
    output logic pulse
);

    localparam int unsigned LEN_W = $clog2(LEN + 1);

    logic             trig_d;
    logic [LEN_W-1:0] left;

    // Edge memory and countdown: load LEN on a trigger rise, then drain.
    always_ff @(posedge clk) begin
        if (!rst_n || pd) begin
            trig_d <= 1'b0;
            left   <= '0;
        end else begin
            trig_d <= trig;
            if (trig && !trig_d)  left <= LEN_W'(LEN);
            else if (left != '0)  left <= left - 1'b1;
        end
    end

    assign pulse = (left != '0);

    AST_OSH_LOAD: assert property (@(posedge clk) disable iff (!rst_n || pd)
        (trig && !trig_d) |=> pulse); // R4

endmodule

// File: rtl/irs_sir_encoder.sv
// Module: top of the infrared serial pulse encoder.
// Assumes one crystal-rate clock; txd and ext_clk16 are asynchronous.
// Chooses the tick source, runs the cell modulator, optionally shortens the
// pulse with the one-shot, and registers the emitter drive.
module irs_sir_encoder #(
    parameter int unsigned CELL        = 16,
    parameter int unsigned LEAD        = 7,
    parameter int unsigned HIGH        = 3,
    parameter int unsigned OSH_LEN     = 6,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          HAS_ONESHOT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txd,
    input  logic       ext_clk16,
    input  logic       ext_sel,
    input  logic [2:0] rate_code,
    input  logic       pulse_mode,
    input  logic       pwr_dn,
    output logic       ir_txd
);

    logic txd_s;
    logic tick;
    logic mod;
    logic osh;
    logic use_osh;
    logic ir_q;

    irs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_txd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (txd),
        .q     (txd_s)
    );

    irs_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd        (pwr_dn),
        .ext_sel   (ext_sel),
        .rate_code (rate_code),
        .ext_clk16 (ext_clk16),
        .tick      (tick)
    );

    irs_sir_mod #(.CELL(CELL), .LEAD(LEAD), .HIGH(HIGH)) u_mod (
        .clk   (clk),
        .rst_n (rst_n),
        .pd    (pwr_dn),
        .tick  (tick),
        .txd_s (txd_s),
        .mod   (mod)
    );

    generate
        if (HAS_ONESHOT) begin : g_osh
            irs_oneshot #(.LEN(OSH_LEN)) u_osh (
                .clk   (clk),
                .rst_n (rst_n),
                .pd    (pwr_dn),
                .trig  (mod),
                .pulse (osh)
            );
        end else begin : g_no_osh
            assign osh = 1'b0;
        end
    endgenerate

    assign use_osh = HAS_ONESHOT && pulse_mode && !ext_sel;

    // Output register: dark in reset and power-down, else the selected shape.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) ir_q <= 1'b0;
        else                  ir_q <= use_osh ? osh : mod;
    end

    assign ir_txd = ir_q;

    // Checker state: length of the current high run on the output.
    logic [7:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n)           hi_run <= '0;
        else if (!ir_q)       hi_run <= '0;
        else if (hi_run != '1) hi_run <= hi_run + 1'b1;
    end

    AST_PD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !ir_txd); // R8

    AST_OSH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
        (use_osh && $stable(use_osh)) |-> (hi_run <= 8'(OSH_LEN))); // R4

endmodule

// File: tb/tb_irs_sir_encoder.sv
module tb_irs_sir_encoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txd = 1'b1;
    logic       ext_clk16 = 1'b0;
    logic       ext_sel = 1'b0;
    logic [2:0] rate_code = 3'd0;
    logic       pulse_mode = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       ir_txd;

    localparam int EXT_H = 4;           // external 16x clock half period
    localparam int EXT_P = 2 * EXT_H;

    irs_sir_encoder dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .txd        (txd),
        .ext_clk16  (ext_clk16),
        .ext_sel    (ext_sel),
        .rate_code  (rate_code),
        .pulse_mode (pulse_mode),
        .pwr_dn     (pwr_dn),
        .ir_txd     (ir_txd)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // External 16x clock generator.
    bit ext_run = 1'b0;
    int ext_ph = 0;
    always @(negedge clk) begin
        if (ext_run) begin
            if (ext_ph == EXT_H - 1) begin
                ext_ph = 0;
                ext_clk16 = ~ext_clk16;
            end else ext_ph = ext_ph + 1;
        end
    end

    // Output monitor: records rising-edge times and high widths.
    int rise_t [32];
    int wid [32];
    int n_rise = 0;
    int n_fall = 0;
    logic prev_ir = 1'b0;
    always @(negedge clk) begin
        if (ir_txd && !prev_ir && n_rise < 32) begin
            rise_t[n_rise] = cyc;
            n_rise = n_rise + 1;
        end
        if (!ir_txd && prev_ir && n_fall < 32 && n_rise > 0) begin
            wid[n_fall] = cyc - rise_t[n_rise-1];
            n_fall = n_fall + 1;
        end
        prev_ir = ir_txd;
    end

    task automatic clear_mon();
        n_rise = 0;
        n_fall = 0;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input int code);
        case (code)
            0: return 2;  1: return 4;  2: return 12; 3: return 24;
            4: return 6;  5: return 48; default: return 96;
        endcase
    endfunction

    // Sends eight bits LSB first, each 16*tper cycles, then idles two bits.
    task automatic send_frame(input int tper, input logic [7:0] pat,
                              input int exp_w, input bit ext, input string tag);
        int zi [8];
        int nz = 0;
        int t0;
        clear_mon();
        @(negedge clk);
        t0 = cyc;
        for (int i = 0; i < 8; i++) begin
            txd = pat[i];
            if (!pat[i]) begin zi[nz] = i; nz = nz + 1; end
            repeat (16 * tper) @(negedge clk);
        end
        txd = 1'b1;
        repeat (32 * tper) @(negedge clk);
        // R2 R3: one pulse per space, none per mark.
        chk(n_rise == nz, {tag, " R3 pulse count"}, n_rise, nz);
        chk(n_fall == n_rise, {tag, " R3 falls"}, n_fall, n_rise);
        for (int k = 0; k < n_fall && k < nz; k++)
            chk(wid[k] == exp_w, {tag, " width R1/R4/R6"}, wid[k], exp_w);
        for (int k = 1; k < n_rise && k < nz; k++)
            chk(rise_t[k] - rise_t[0] == (zi[k] - zi[0]) * 16 * tper,
                {tag, " spacing R2"}, rise_t[k] - rise_t[0], (zi[k] - zi[0]) * 16 * tper);
        if (n_rise > 0) begin
            if (!ext)
                chk((rise_t[0] - t0 >= 7 * tper + 4) && (rise_t[0] - t0 <= 8 * tper + 4),
                    {tag, " lead-in R10"}, rise_t[0] - t0, 7 * tper + 4);
            else
                chk((rise_t[0] - t0 >= 7 * tper + 4) && (rise_t[0] - t0 <= 8 * tper + 8),
                    {tag, " lead-in R7"}, rise_t[0] - t0, 7 * tper + 4);
        end
    endtask

    task automatic wait_high(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (ir_txd) seen = 1'b1;
        end
    endtask

    initial begin
        bit seen;
        int any_hi;
        repeat (4) @(negedge clk);
        chk(ir_txd == 1'b0, "R9 reset state", ir_txd, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3: long mark, no pulses.
        clear_mon();
        txd = 1'b1;
        repeat (400) @(negedge clk);
        chk(n_rise == 0, "R3 idle mark", n_rise, 0);

        // R1 R2 R6 R10: default shape, every rate code.
        pulse_mode = 1'b0;
        for (int c = 0; c < 8; c++) begin
            rate_code = 3'(c);
            send_frame(ratio_of(c), 8'b1011_0100, 3 * ratio_of(c), 1'b0,
                       $sformatf("R6 code%0d", c));
        end

        // R4: one-shot shape, every rate code.
        pulse_mode = 1'b1;
        for (int c = 0; c < 8; c++) begin
            rate_code = 3'(c);
            send_frame(ratio_of(c), 8'b1011_0100, 6, 1'b0,
                       $sformatf("R4 code%0d", c));
        end

        // R7 R5: external tick, with and without pulse_mode.
        ext_run = 1'b1;
        ext_sel = 1'b1;
        rate_code = 3'd0;
        repeat (40) @(negedge clk);
        pulse_mode = 1'b0;
        send_frame(EXT_P, 8'b0100_1100, 3 * EXT_P, 1'b1, "R7 ext");
        pulse_mode = 1'b1;
        send_frame(EXT_P, 8'b0100_1100, 3 * EXT_P, 1'b1, "R5 ext pulse_mode");
        ext_sel = 1'b0;
        ext_run = 1'b0;
        pulse_mode = 1'b0;
        repeat (40) @(negedge clk);

        // R8: power-down on the first high cycle of a pulse.
        rate_code = 3'd1;
        txd = 1'b0;
        wait_high(seen);
        chk(seen, "R8 pulse before power-down", seen, 1);
        pwr_dn = 1'b1;
        @(negedge clk);
        chk(ir_txd == 1'b0, "R8 dark next cycle", ir_txd, 0);
        any_hi = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (ir_txd) any_hi = any_hi + 1;
        end
        chk(any_hi == 0, "R8 dark while down", any_hi, 0);
        txd = 1'b1;
        repeat (8) @(negedge clk);
        clear_mon();
        pwr_dn = 1'b0;
        repeat (300) @(negedge clk);
        chk(n_rise == 0, "R8 no leftover pulse", n_rise, 0);
        send_frame(4, 8'b1111_1100, 12, 1'b0, "R8 after release");

        // R9: reset in the middle of a pulse.
        txd = 1'b0;
        wait_high(seen);
        chk(seen, "R9 pulse before reset", seen, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ir_txd == 1'b0, "R9 dark in reset", ir_txd, 0);
        txd = 1'b1;
        repeat (8) @(negedge clk);
        clear_mon();
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        chk(n_rise == 0, "R9 state cleared", n_rise, 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule